// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Protection

This block caches recent virtual-to-physical page translations. Every lookup compares the virtual page number against all entries at once. When a valid entry matches and its permission bits allow the access, the block forms the physical address from the entry's frame number and the untranslated page offset. All of this happens combinationally, in the same cycle as the request. When a valid entry matches but its permission bits refuse the access, the block raises a protection fault instead of a hit.

After a miss, a refill port writes a translation into the cache on the next clock edge. The entry it writes is chosen as follows:
- an entry that already holds the same tag is overwritten;
- otherwise the lowest-numbered invalid entry is used;
- otherwise a round-robin pointer picks the victim.

Because of this choice, two valid entries never share a tag. A single input clears every valid bit at once, for example on an address-space switch.

With the default parameters there are 32 entries, a 43-bit virtual address, a 13-bit page offset, a 21-bit frame number and a 34-bit physical address.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no entry is valid, so every lookup gives hit=0 and prot_fault=0.
- R2: With lk_valid=1, an access hits in the same cycle when a valid entry's tag equals lk_vaddr[42:13] and that entry permits the access.
- R3: On a hit, paddr equals {frame, lk_vaddr[12:0]}, with the frame in bits 33:13. Whenever hit=0, paddr is zero.
- R4: A load (lk_write=0) is judged against the entry's read field and a store (lk_write=1) against its write field. In each 2-bit field, bit 0 grants supervisor access (lk_user=0) and bit 1 grants user access (lk_user=1).
- R5: A tag match whose permission bit is clear gives prot_fault=1 and hit=0 in the same cycle.
- R6: With lk_valid=0, both hit and prot_fault are 0 whatever the address.
- R7: A refill is written at the clock edge. A lookup made in the same cycle as the refill sees the old contents, and the new translation is visible from the next cycle.
- R8: A refill whose tag is already held by a valid entry overwrites that entry and does not move the replacement pointer.
- R9: Otherwise, a refill goes to the lowest-numbered invalid entry.
- R10: When all entries are valid and none matches the refill tag, the entry named by a round-robin pointer is replaced. The pointer is 0 after reset, advances by one (wrapping) only on such a replacement, and is otherwise unchanged.
- R11: When inv_all is high, every valid bit clears at the clock edge, a refill in the same cycle is dropped, and the replacement pointer keeps its value.
- R12: No two valid entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_vaddr | input | 43 | Virtual address of the access |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor |
| hit | output | 1 | Permitted translation found |
| prot_fault | output | 1 | Translation found but access refused |
| paddr | output | 34 | Physical address, zero unless hit |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | 30 | Virtual page number to install |
| fill_frame | input | 21 | Physical frame number to install |
| fill_rd_perm | input | 2 | Read permission field (bit0 supervisor, bit1 user) |
| fill_wr_perm | input | 2 | Write permission field (bit0 supervisor, bit1 user) |
| inv_all | input | 1 | Clear every valid bit |

## Verification
The assertions assume that entries are installed only through the refill port, and that the inputs are known (not X) outside reset. The single-match check rests on the refill target choice alone, not on anything outside the block. The bench changes inputs only at falling edges. It builds every page number by multiplying a distinct index by an odd constant, so page numbers can repeat only where a test means to overwrite. It keeps its own model of the entry contents and of the replacement pointer, and derives from that model which translation must have been evicted.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PERM_W   = 2;
  localparam int PERM_SUP = 0;
  localparam int PERM_USR = 1;

  function automatic logic perm_allows(input logic [PERM_W-1:0] field, input logic user);
    return user ? field[PERM_USR] : field[PERM_SUP];
  endfunction
endpackage

// File: rtl/tlb_cam_array.sv
module tlb_cam_array
  import tlb_pkg::*;
#(
  parameter int N       = 32,
  parameter int TAG_W   = 30,
  parameter int FRAME_W = 21,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [PERM_W-1:0]  wr_rd,
  input  logic [PERM_W-1:0]  wr_wr,
  input  logic               clr_all,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic               lk_write,
  input  logic               lk_user,
  input  logic [TAG_W-1:0]   fill_tag,
  output logic [N-1:0]       vld_o,
  output logic [N-1:0]       lk_match_o,
  output logic [N-1:0]       perm_ok_o,
  output logic [N-1:0]       fill_match_o,
  output logic [FRAME_W-1:0] frame_o [N]
);
  logic [N-1:0]       vld_q, vld_d;
  logic [TAG_W-1:0]   tag_q   [N];
  logic [FRAME_W-1:0] frame_q [N];
  logic [PERM_W-1:0]  rd_q    [N];
  logic [PERM_W-1:0]  wrp_q   [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (clr_all)                               vld_d[i] = 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(i)))   vld_d[i] = 1'b1;
      else                                       vld_d[i] = vld_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic ent_we;
    logic [PERM_W-1:0] sel_perm;
    assign ent_we = wr_en && !clr_all && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (ent_we) begin
        tag_q[i]   <= wr_tag;
        frame_q[i] <= wr_frame;
        rd_q[i]    <= wr_rd;
        wrp_q[i]   <= wr_wr;
      end
    end

    assign sel_perm        = lk_write ? wrp_q[i] : rd_q[i];
    assign lk_match_o[i]   = vld_q[i] && (tag_q[i] == lk_tag);
    assign fill_match_o[i] = vld_q[i] && (tag_q[i] == fill_tag);
    assign perm_ok_o[i]    = perm_allows(sel_perm, lk_user);
    assign frame_o[i]      = frame_q[i];
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N      = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     fill_match,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] inv_idx, same_idx;
  logic             any_inv, any_same, use_ptr;

  always_comb begin
    any_inv = 1'b0;
    inv_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        any_inv = 1'b1;
        inv_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    any_same = 1'b0;
    same_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (fill_match[i]) begin
        any_same = 1'b1;
        same_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (any_same)     idx_o = same_idx;
    else if (any_inv) idx_o = inv_idx;
    else              idx_o = ptr_q;
  end

  assign use_ptr = fill_en && !any_same && !any_inv;

  always_comb begin
    ptr_d = ptr_q;
    if (use_ptr) ptr_d = (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/tlb_frame_sel.sv
module tlb_frame_sel #(
  parameter int N = 32,
  parameter int W = 21
) (
  input  logic [N-1:0] sel,
  input  logic [W-1:0] din [N],
  output logic [W-1:0] dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) dout = dout | (din[i] & {W{sel[i]}});
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int VA_W        = 43,
  parameter int OFF_W       = 13,
  parameter int FRAME_W     = 21,
  localparam int TAG_W      = VA_W - OFF_W,
  localparam int PA_W       = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic               lk_write,
  input  logic               lk_user,
  output logic               hit,
  output logic               prot_fault,
  output logic [PA_W-1:0]    paddr,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [PERM_W-1:0]  fill_rd_perm,
  input  logic [PERM_W-1:0]  fill_wr_perm,
  input  logic               inv_all
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  logic [NUM_ENTRIES-1:0] vld_q, lk_match, perm_ok, fill_match, hit_vec;
  logic [FRAME_W-1:0]     ent_frame [NUM_ENTRIES];
  logic [FRAME_W-1:0]     sel_frame;
  logic [IDX_W-1:0]       wr_idx;
  logic                   wr_en;

  assign wr_en = fill_en && !inv_all;

  tlb_cam_array #(.N(NUM_ENTRIES), .TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(fill_vpn), .wr_frame(fill_frame),
    .wr_rd(fill_rd_perm), .wr_wr(fill_wr_perm), .clr_all(inv_all),
    .lk_tag(lk_vaddr[VA_W-1:OFF_W]), .lk_write(lk_write), .lk_user(lk_user),
    .fill_tag(fill_vpn),
    .vld_o(vld_q), .lk_match_o(lk_match), .perm_ok_o(perm_ok),
    .fill_match_o(fill_match), .frame_o(ent_frame)
  );

  tlb_victim #(.N(NUM_ENTRIES)) u_vict (
    .clk(clk), .rst_n(rst_n), .fill_en(wr_en), .vld(vld_q),
    .fill_match(fill_match), .idx_o(wr_idx)
  );

  assign hit_vec = lk_match & perm_ok & {NUM_ENTRIES{lk_valid}};

  tlb_frame_sel #(.N(NUM_ENTRIES), .W(FRAME_W)) u_sel (
    .sel(hit_vec), .din(ent_frame), .dout(sel_frame)
  );

  assign hit        = |hit_vec;
  assign prot_fault = lk_valid && |(lk_match & ~perm_ok);
  assign paddr      = {sel_frame, lk_vaddr[OFF_W-1:0] & {OFF_W{hit}}};
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int NUM_ENTRIES = 32,
  parameter int VA_W        = 43,
  parameter int OFF_W       = 13,
  parameter int FRAME_W     = 21
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         lk_valid,
  input logic [VA_W-1:0]              lk_vaddr,
  input logic                         hit,
  input logic                         prot_fault,
  input logic [FRAME_W+OFF_W-1:0]     paddr,
  input logic                         fill_en,
  input logic [VA_W-OFF_W-1:0]        fill_vpn,
  input logic                         inv_all,
  input logic [NUM_ENTRIES-1:0]       vld_q,
  input logic [NUM_ENTRIES-1:0]       lk_match
);
  // R12
  uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_match));
  // R5
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hit && prot_fault));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |-> (!hit && !prot_fault));
  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !hit |-> (paddr == '0));
  // R11
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) inv_all |=> (vld_q == '0));
  // R7
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(fill_en && !inv_all) && (lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)))
      |-> (hit || prot_fault));
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)
) u_chk (.*);

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;
  localparam int N = 32, VA_W = 43, OFF_W = 13, FRAME_W = 21;
  localparam int TAG_W = VA_W - OFF_W, PA_W = FRAME_W + OFF_W;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid, lk_write, lk_user;
  logic [VA_W-1:0] lk_vaddr;
  logic hit, prot_fault;
  logic [PA_W-1:0] paddr;
  logic fill_en, inv_all;
  logic [TAG_W-1:0] fill_vpn;
  logic [FRAME_W-1:0] fill_frame;
  logic [1:0] fill_rd_perm, fill_wr_perm;

  always #2.5 clk = ~clk;

  tlb_xlate dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic             m_vld   [N];
  logic [TAG_W-1:0] m_tag   [N];
  logic [FRAME_W-1:0] m_frame [N];
  logic [1:0]       m_rd    [N];
  logic [1:0]       m_wr    [N];
  int               m_ptr;
  logic [TAG_W-1:0] last_evicted;
  bit               last_was_evict;

  function automatic logic [TAG_W-1:0] mk_tag(int k);
    return TAG_W'(k * 30'h0123_4567 + 30'h11);
  endfunction
  function automatic logic [FRAME_W-1:0] mk_frame(int k);
    return FRAME_W'(k * 21'h09E37 + 21'h3);
  endfunction

  task automatic model_fill(input logic [TAG_W-1:0] t, input logic [FRAME_W-1:0] f,
                            input logic [1:0] rd, input logic [1:0] wr);
    int tgt = -1;
    last_was_evict = 0;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == t) tgt = i;
    if (tgt < 0) for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) tgt = i;
    if (tgt < 0) begin
      tgt = m_ptr;
      last_evicted = m_tag[tgt];
      last_was_evict = 1;
      m_ptr = (m_ptr + 1) % N;
    end
    m_vld[tgt] = 1'b1; m_tag[tgt] = t; m_frame[tgt] = f; m_rd[tgt] = rd; m_wr[tgt] = wr;
  endtask

  task automatic do_fill(input logic [TAG_W-1:0] t, input logic [FRAME_W-1:0] f,
                         input logic [1:0] rd, input logic [1:0] wr);
    @(negedge clk);
    fill_en = 1; fill_vpn = t; fill_frame = f; fill_rd_perm = rd; fill_wr_perm = wr;
    model_fill(t, f, rd, wr);
    @(posedge clk); #1;
    fill_en = 0;
  endtask

  task automatic compare(input logic [TAG_W-1:0] t, input logic [OFF_W-1:0] off,
                         input logic wr, input logic usr, input logic vld, input string req);
    logic eh = 0, ef = 0;
    logic [PA_W-1:0] ep = '0;
    for (int i = 0; i < N; i++) begin
      if (vld && m_vld[i] && m_tag[i] == t) begin
        if ((wr ? m_wr[i][usr] : m_rd[i][usr])) begin eh = 1; ep = {m_frame[i], off}; end
        else ef = 1;
      end
    end
    checks++;
    if (hit !== eh || prot_fault !== ef || paddr !== ep) begin
      errors++;
      $display("FAIL %s: hit/fault/paddr got %b/%b/%h expected %b/%b/%h",
               req, hit, prot_fault, paddr, eh, ef, ep);
    end
  endtask

  task automatic look(input logic [TAG_W-1:0] t, input logic [OFF_W-1:0] off,
                      input logic wr, input logic usr, input string req);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = {t, off}; lk_write = wr; lk_user = usr;
    #1 compare(t, off, wr, usr, 1'b1, req);
    lk_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; lk_valid = 0; lk_vaddr = '0; lk_write = 0; lk_user = 0;
    fill_en = 0; inv_all = 0; fill_vpn = '0; fill_frame = '0; fill_rd_perm = '0; fill_wr_perm = '0;
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_frame[i] = '0; m_rd[i] = '0; m_wr[i] = '0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    for (int k = 0; k < 4; k++) look(mk_tag(k), OFF_W'(k * 91), k[0], k[1], "R1");

    // R9 R2 R3: fill every entry, look each up
    for (int k = 0; k < N; k++) do_fill(mk_tag(k), mk_frame(k), 2'b11, 2'b11);
    for (int k = 0; k < N; k++) look(mk_tag(k), OFF_W'(k * 37 + 5), k[0], k[1], "R2 R3");

    // R4 R5 R8: permission sweep by overwriting one tag
    for (int p = 0; p < 16; p++) begin
      do_fill(mk_tag(5), mk_frame(100 + p), 2'(p), 2'(p >> 2));
      for (int a = 0; a < 4; a++) look(mk_tag(5), OFF_W'(p * 255 + a), a[0], a[1], "R4 R5 R8");
    end
    do_fill(mk_tag(5), mk_frame(5), 2'b11, 2'b11);

    // R6: no request, matching address
    @(negedge clk);
    lk_valid = 0; lk_vaddr = {mk_tag(3), 13'h1ABC}; lk_write = 0; lk_user = 0;
    #1 compare(mk_tag(3), 13'h1ABC, 1'b0, 1'b0, 1'b0, "R6");

    // R7: lookup in refill cycle sees old contents
    @(negedge clk);
    fill_en = 1; fill_vpn = mk_tag(200); fill_frame = mk_frame(200); fill_rd_perm = 2'b11; fill_wr_perm = 2'b01;
    lk_valid = 1; lk_vaddr = {mk_tag(200), 13'h0042}; lk_write = 0; lk_user = 1;
    #1 compare(mk_tag(200), 13'h0042, 1'b0, 1'b1, 1'b1, "R7");
    model_fill(mk_tag(200), mk_frame(200), 2'b11, 2'b01);
    @(posedge clk); #1; fill_en = 0; lk_valid = 0;
    look(mk_tag(200), 13'h0042, 1'b0, 1'b1, "R7");
    look(last_evicted, 13'h0007, 1'b0, 1'b0, "R10");

    // R10: round-robin replacement when full
    for (int k = 201; k < 240; k++) begin
      do_fill(mk_tag(k), mk_frame(k), 2'b11, 2'b11);
      look(mk_tag(k), OFF_W'(k), 1'b1, 1'b0, "R10");
      if (last_was_evict) look(last_evicted, OFF_W'(k + 1), 1'b0, 1'b0, "R10");
    end

    // R11: invalidate all, refill in same cycle dropped
    @(negedge clk);
    inv_all = 1; fill_en = 1; fill_vpn = mk_tag(300); fill_frame = mk_frame(300);
    fill_rd_perm = 2'b11; fill_wr_perm = 2'b11;
    @(posedge clk); #1; inv_all = 0; fill_en = 0;
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    look(mk_tag(300), 13'h0100, 1'b0, 1'b0, "R11");
    for (int k = 201; k < 240; k++) look(mk_tag(k), OFF_W'(k), 1'b0, 1'b0, "R11");

    // R9 R10 R11: refill lowest-first, then pointer kept across invalidate
    for (int k = 400; k < 400 + N; k++) do_fill(mk_tag(k), mk_frame(k), 2'b01, 2'b10);
    for (int k = 400; k < 400 + N; k++) look(mk_tag(k), OFF_W'(k), 1'b0, 1'b0, "R9");
    do_fill(mk_tag(500), mk_frame(500), 2'b11, 2'b11);
    look(last_evicted, 13'h0055, 1'b0, 1'b0, "R10 R11");
    look(mk_tag(500), 13'h0055, 1'b1, 1'b1, "R10");
    for (int k = 400; k < 400 + N; k++) look(mk_tag(k), OFF_W'(k), 1'b1, 1'b1, "R9 R4");

    finish_run();
  end
endmodule